// File: doc/BRIEF.md
# Approximate Radix-8 Booth Multiplier

This block multiplies two signed two's-complement operands and returns a double-width product, trading a small, bounded loss of accuracy for a shorter critical path. The multiplier operand is recoded into radix-8 Booth digits, each in the range -4 to +4. Every digit then selects one multiple of the multiplicand: zero, once, twice, three times or four times. The multiples that are powers of two are only wiring. The three-times multiple is the slow one, and it is built once by an adder whose low-order part is deliberately approximate.

The low bits of that adder are formed by independent 2-bit slices. Each slice adds a bit pair of x to the matching bit pair of 2x modulo 4 and throws away its carry. The remaining upper bits are added exactly, with a carry-in of zero. As a result, no carry ripples through the low region. A build-time parameter selects a second, cheaper mode in which the lowest partial-product columns are discarded before accumulation. The block is purely combinational and is meant to sit in arithmetic datapaths that can tolerate error, such as filtering or imaging.

Top module: `apxb_mul`

## Requirements
- R1: When truncation is disabled and no Booth digit of the multiplier is ±3, `prod` equals the exact product `mcand * mplier` as a 24-bit two's-complement value.
- R2: The multiplier is recoded into 4 digits. Digit i is -4*m[3i+2] + 2*m[3i+1] + m[3i] + m[3i-1], with m[-1] = 0. Multipliers whose digits take every value in {-4, -2, -1, 0, 1, 2, 4} give the exact product.
- R3: With truncation disabled, `prod` equals the sum over i of digit_i * M(|digit_i|) * 8^i, taken modulo 2^24. Here M(k) = k*x for k other than 3. M(3) is the approximate triple: its bits 5:0 are three slices, and slice k equals (x[2k+1:2k] + (2x)[2k+1:2k]) mod 4. Its upper bits are the exact sum of the upper bits of x and 2x, with a carry-in of zero.
- R4: With truncation disabled, |exact product - `prod`| never exceeds 49140, which is 84*(1+8+64+512).
- R5: With truncation enabled, each row is formed before summation. A row with a positive digit is M sign-extended and shifted by 3i. A row with a negative digit is the bitwise complement of M, sign-extended and shifted, plus a correction 1 at column 3i; a zero digit gives an all-zero row with no correction. Every bit in columns 0 to 14, correction bits included, is dropped before summation.
- R6: With truncation enabled, `prod[14:0]` is always zero.
- R7: With truncation enabled, (R3 value - `prod`) mod 2^24 lies in [0, 131653], which is 4*(2^15-1) + 585.
- R8: A zero multiplier gives a zero product in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 12 | Signed multiplicand x |
| mplier | input | 12 | Signed multiplier, Booth-recoded |
| prod | output | 24 | Approximate signed product |

## Verification
The bench builds two copies of the block, both with 12-bit operands and a 6-bit approximate region. Instance `u0` keeps every column, so the bench can compare it bit for bit against its own model of the approximate triple and check the error bound against the exact product. Instance `u1` sets the truncation parameter with 15 dropped columns. This makes the row-complement encoding and the dropped correction bits observable, because its result differs from the full-width sum in a predictable way. Random operands are mixed with the extreme value -2048 on both sides, all-ones operands, zeros and multipliers chosen to produce each digit value.

// File: rtl/apxb_pkg.sv
package apxb_pkg;

    // Magnitude selection for one Booth digit
    typedef enum logic [2:0] {
        MAG_0  = 3'd0,
        MAG_1X = 3'd1,
        MAG_2X = 3'd2,
        MAG_3X = 3'd3,
        MAG_4X = 3'd4
    } mag_e;

    typedef struct packed {
        logic neg;   // digit is strictly negative
        mag_e mag;   // absolute value of the digit
    } bdig_t;

    // Turn a 4-bit overlapping group into a signed digit
    function automatic bdig_t booth_decode(input logic [3:0] grp);
        bdig_t d;
        int    v;
        v = -4 * int'(grp[3]) + 2 * int'(grp[2]) + int'(grp[1]) + int'(grp[0]);
        d.neg = (v < 0);
        d.mag = mag_e'(3'(d.neg ? -v : v));
        return d;
    endfunction

    function automatic int bdig_value(input bdig_t d);
        int m;
        m = int'(d.mag);
        return d.neg ? -m : m;
    endfunction

    // Worst-case deficit of the carry-free low region (sum of lost carries)
    function automatic int apx_max_err(input int apx_bits);
        int e;
        e = 0;
        for (int k = 0; k < apx_bits / 2; k++) e += 1 << (2 * k + 2);
        return e;
    endfunction

endpackage

// File: rtl/apxb_recoder.sv
module apxb_recoder
    import apxb_pkg::*;
#(
    parameter int OPW  = 12,
    parameter int NDIG = (OPW + 2) / 3
) (
    input  logic [OPW-1:0]          mplr,
    output bdig_t [NDIG-1:0]        digs
);
    localparam int EXTW = 3 * NDIG;

    logic signed [EXTW-1:0] sx;
    logic [EXTW:0]          ext;

    always_comb begin
        sx  = EXTW'(signed'(mplr));
        ext = {sx, 1'b0};
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign digs[i] = booth_decode(ext[3*i+3 -: 4]);
    end

    // The weighted digit sum must give back the multiplier value
    always_comb begin
        int acc;
        int w;
        acc = 0;
        w   = 1;
        for (int i = 0; i < NDIG; i++) begin
            acc += bdig_value(digs[i]) * w;
            w   *= 8;
        end
        if (!$isunknown(mplr)) begin
            AST_DIGIT_SUM: assert (acc == int'(signed'(mplr)));          // R2
        end
    end

endmodule

// File: rtl/apxb_triple.sv
module apxb_triple
    import apxb_pkg::*;
#(
    parameter int OPW = 12,
    parameter int APX = 6,
    parameter int MW  = OPW + 3
) (
    input  logic [OPW-1:0] mcand,
    output logic [MW-1:0]  triple
);
    localparam int NSLC   = APX / 2;
    localparam int MAXERR = apx_max_err(APX);

    logic [MW-1:0] x1;
    logic [MW-1:0] x2;

    always_comb begin
        x1 = MW'(signed'(mcand));
        x2 = {x1[MW-2:0], 1'b0};
    end

    // Carry-free 2-bit slices in the approximate region
    for (genvar k = 0; k < NSLC; k++) begin : g_slice
        assign triple[2*k+1 -: 2] = x1[2*k+1 -: 2] + x2[2*k+1 -: 2];
    end

    // Exact region, carry-in tied to zero
    if (APX > 0) begin : g_upper_apx
        assign triple[MW-1:APX] = x1[MW-1:APX] + x2[MW-1:APX];
    end else begin : g_upper_all
        assign triple = x1 + x2;
    end

    // The approximation may only fall short of 3x, and by at most the lost carries
    always_comb begin
        logic [MW-1:0] full3;
        logic [MW-1:0] short;
        full3 = x1 + x2;
        short = full3 - triple;
        if (!$isunknown(mcand)) begin
            AST_TRIPLE_BOUND: assert (int'(short) <= MAXERR);            // R3
        end
    end

endmodule

// File: rtl/apxb_pprow.sv
module apxb_pprow
    import apxb_pkg::*;
#(
    parameter int OPW = 12,
    parameter int MW  = OPW + 3
) (
    input  logic [OPW-1:0] mcand,
    input  logic [MW-1:0]  triple,
    input  bdig_t          dig,
    output logic [MW-1:0]  row,
    output logic           corr
);
    logic [MW-1:0] m1;
    logic [MW-1:0] sel;

    always_comb begin
        m1 = MW'(signed'(mcand));
        unique case (dig.mag)
            MAG_1X:  sel = m1;
            MAG_2X:  sel = {m1[MW-2:0], 1'b0};
            MAG_3X:  sel = triple;
            MAG_4X:  sel = {m1[MW-3:0], 2'b00};
            default: sel = '0;
        endcase
        row  = dig.neg ? ~sel : sel;
        corr = dig.neg;
    end

    // A zero digit contributes nothing at all
    always_comb begin
        if (!$isunknown(dig) && !$isunknown(mcand) && dig.mag == MAG_0) begin
            AST_ZERO_ROW: assert (row == '0 && !corr);                   // R5
        end
    end

endmodule

// File: rtl/apxb_accum.sv
module apxb_accum #(
    parameter int MW         = 15,
    parameter int NDIG       = 4,
    parameter int PW         = 24,
    parameter bit TRUNC_EN   = 1'b0,
    parameter int TRUNC_COLS = 15
) (
    input  logic [NDIG-1:0][MW-1:0] rows,
    input  logic [NDIG-1:0]         corr,
    output logic [PW-1:0]           prod
);
    localparam logic [PW-1:0] KEEP =
        TRUNC_EN ? ~((PW'(1) << TRUNC_COLS) - PW'(1)) : {PW{1'b1}};

    always_comb begin
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NDIG; i++) begin
            acc += (PW'(signed'(rows[i])) << (3 * i)) & KEEP;
            acc += (PW'(corr[i]) << (3 * i)) & KEEP;
        end
        prod = acc;
    end

    if (TRUNC_EN) begin : g_trunc_chk
        always_comb begin
            if (!$isunknown(prod)) begin
                AST_LOW_COLS_ZERO: assert ((prod & ~KEEP) == '0);        // R6
            end
        end
    end

endmodule

// File: rtl/apxb_mul.sv
module apxb_mul
    import apxb_pkg::*;
#(
    parameter int OPW        = 12,
    parameter int APX_BITS   = 6,
    parameter bit TRUNC_EN   = 1'b0,
    parameter int TRUNC_COLS = 15
) (
    input  logic [OPW-1:0]   mcand,
    input  logic [OPW-1:0]   mplier,
    output logic [2*OPW-1:0] prod
);
    localparam int NDIG = (OPW + 2) / 3;
    localparam int MW   = OPW + 3;
    localparam int PW   = 2 * OPW;

    bdig_t [NDIG-1:0]       digs;
    logic  [MW-1:0]         triple;
    logic  [NDIG-1:0][MW-1:0] rows;
    logic  [NDIG-1:0]       corr;

    apxb_recoder #(.OPW(OPW), .NDIG(NDIG)) u_rec (
        .mplr (mplier),
        .digs (digs)
    );

    apxb_triple #(.OPW(OPW), .APX(APX_BITS), .MW(MW)) u_tri (
        .mcand  (mcand),
        .triple (triple)
    );

    for (genvar i = 0; i < NDIG; i++) begin : g_row
        apxb_pprow #(.OPW(OPW), .MW(MW)) u_row (
            .mcand  (mcand),
            .triple (triple),
            .dig    (digs[i]),
            .row    (rows[i]),
            .corr   (corr[i])
        );
    end

    apxb_accum #(
        .MW(MW), .NDIG(NDIG), .PW(PW),
        .TRUNC_EN(TRUNC_EN), .TRUNC_COLS(TRUNC_COLS)
    ) u_acc (
        .rows (rows),
        .corr (corr),
        .prod (prod)
    );

    always_comb begin
        logic any3;
        logic [PW-1:0] exact;
        any3 = 1'b0;
        for (int i = 0; i < NDIG; i++) any3 |= (digs[i].mag == MAG_3X);
        exact = PW'(signed'(mcand)) * PW'(signed'(mplier));
        if (!$isunknown({mcand, mplier, prod})) begin
            if (!TRUNC_EN && !any3) begin
                AST_EXACT_NO3: assert (prod == exact);                   // R1
            end
            if (mplier == '0) begin
                AST_ZERO_MPLR: assert (prod == '0);                      // R8
            end
        end
    end

endmodule

// File: tb/sim_apxb_mul.sv
module sim_apxb_mul;

    logic        clk = 1'b0;
    logic [11:0] mc  = '0;
    logic [11:0] mp  = '0;
    logic [23:0] p_full;
    logic [23:0] p_trunc;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    apxb_mul #(.OPW(12), .APX_BITS(6), .TRUNC_EN(1'b0), .TRUNC_COLS(15)) u0 (
        .mcand(mc), .mplier(mp), .prod(p_full));
    apxb_mul #(.OPW(12), .APX_BITS(6), .TRUNC_EN(1'b1), .TRUNC_COLS(15)) u1 (
        .mcand(mc), .mplier(mp), .prod(p_trunc));

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s mc=%0d mp=%0d actual=%h expected=%h", req,
                     $signed(mc), $signed(mp), act, exp);
        end
    endtask

    function automatic int bbit(input int b, input int j);
        return (j < 0) ? 0 : ((b >>> j) & 1);
    endfunction

    function automatic int digit(input int b, input int i);
        return -4 * bbit(b, 3*i+2) + 2 * bbit(b, 3*i+1) + bbit(b, 3*i) + bbit(b, 3*i-1);
    endfunction

    function automatic int tri_apx(input int a);
        int lo;
        int x2;
        x2 = 2 * a;
        lo = 0;
        for (int k = 0; k < 3; k++)
            lo += ((((a >>> (2*k)) & 3) + ((x2 >>> (2*k)) & 3)) & 3) << (2*k);
        return ((a >>> 6) + (x2 >>> 6)) * 64 + lo;
    endfunction

    function automatic int mult_of(input int a, input int k);
        return (k == 3) ? tri_apx(a) : k * a;
    endfunction

    function automatic logic [23:0] model_full(input int a, input int b);
        logic [23:0] s;
        s = '0;
        for (int i = 0; i < 4; i++) begin
            int d;
            int m;
            d = digit(b, i);
            m = mult_of(a, (d < 0) ? -d : d);
            s += 24'(((d < 0) ? -m : m) * (1 << (3*i)));
        end
        return s;
    endfunction

    function automatic logic [23:0] model_trunc(input int a, input int b);
        logic [23:0] s;
        logic [23:0] keep;
        keep = 24'hFF8000;   // columns 15 and up
        s = '0;
        for (int i = 0; i < 4; i++) begin
            int d;
            int r;
            d = digit(b, i);
            r = (d == 0) ? 0 : ((d < 0) ? -mult_of(a, -d) - 1 : mult_of(a, d));
            s += (24'(r) << (3*i)) & keep;
            if (d < 0) s += (24'(1) << (3*i)) & keep;
        end
        return s;
    endfunction

    function automatic bit has3(input int b);
        bit h;
        h = 1'b0;
        for (int i = 0; i < 4; i++) h |= (digit(b, i) == 3 || digit(b, i) == -3);
        return h;
    endfunction

    task automatic run(input int a, input int b, input string tag);
        int sa, sb, exact, got, err;
        logic [23:0] ef, et, dd;
        @(negedge clk);
        mc = 12'(a);
        mp = 12'(b);
        @(posedge clk);
        #1;
        sa = int'($signed(mc));
        sb = int'($signed(mp));
        exact = sa * sb;
        ef = model_full(sa, sb);
        et = model_trunc(sa, sb);
        got = int'($signed(p_full));
        err = exact - got;
        chk(p_full == ef, {"R3 ", tag}, p_full, ef);
        chk(err <= 49140 && err >= -49140, {"R4 ", tag}, p_full, 24'(exact));
        chk(p_trunc == et, {"R5 ", tag}, p_trunc, et);
        chk(p_trunc[14:0] == 15'd0, {"R6 ", tag}, p_trunc, {p_trunc[23:15], 15'd0});
        dd = ef - p_trunc;
        chk(dd <= 24'd131653, {"R7 ", tag}, p_trunc, ef);
        if (!has3(sb)) chk(p_full == 24'(exact), {"R1 ", tag}, p_full, 24'(exact));
        if (sb == 0) begin
            chk(p_full == '0, {"R8 full ", tag}, p_full, '0);
            chk(p_trunc == '0, {"R8 trunc ", tag}, p_trunc, '0);
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(posedge clk);
        #1;
        // reset-free block: all-zero inputs give zero (R8)
        chk(p_full == '0 && p_trunc == '0, "R8 idle", p_full | p_trunc, '0);
        // directed corners
        run(-2048, -2048, "min*min");
        run(-2048, 2047, "min*max");
        run(2047, -2048, "max*min");
        run(0, 1234, "zero mcand");
        run(-1234, 0, "zero mplier R8");
        run(-1, -1, "all ones");
        run(4095, 4095, "all ones raw");
        run(2047, 2047, "max*max");
        run(5, 3, "digit 3");
        run(-5, -3, "digit -3");
        // R2: multipliers hitting digits 1,2,4,-1,-2,-4 (no 3s), exact result
        run(777, 12'b010_001_010_001, "R2 digits+");
        run(-999, 12'b110_101_110_111, "R2 digits-");
        run(1365, 12'b100_000_011_111, "R2 mix");
        for (int n = 0; n < 3000; n++) begin
            run(int'($urandom() & 32'hFFF) - 2048, int'($urandom() & 32'hFFF) - 2048, "random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule